// File: doc/BRIEF.md
# Segmented write request splitter

The block takes one byte-granular write request at a time, given as a start byte address, a byte length and a following stream of data bytes, one byte per cycle. It cuts the request into segment words for a RAM whose bus is split into several interleaved segments. Consecutive segment words of a bus word sit in consecutive segments. Each word is placed in the command slot of the segment it belongs to, together with its word address and byte enables. Only the bytes that the request covers are enabled.

Each segment returns a one-cycle done pulse for every command it finishes. The block counts these pulses per segment and consumes them in the same rotation that the words were issued in. When the last word of a request has been accounted for, it raises a one-cycle completion pulse. A second request can be accepted and issued while the first still waits for its done pulses. Requests that run past the end of the address space, or that have zero length, are refused with a reject pulse and issue nothing.

Top module: `wsplit_write_splitter`

## Requirements
- R1: After reset all segment command valids are low, `busy`, `wreq_reject` and `cmpl_pulse` are low, `byte_ready` is low and `wreq_ready` is high.
- R2: A request with length 0, or with address plus length greater than 2^ADDR_W, is accepted and then refused. `wreq_reject` pulses in the cycle after acceptance. No segment command is issued, `busy` stays low, no completion pulse follows and `byte_ready` stays low. A request ending exactly at 2^ADDR_W is valid.
- R3: Word k of a request goes to segment ((addr / SEG_BYTES) + k) mod SEG_COUNT, with segment word address (addr + k*SEG_BYTES) / (SEG_BYTES*SEG_COUNT). Segment s of word address w covers bytes (w*SEG_COUNT + s)*SEG_BYTES upward.
- R4: A request issues exactly ceil((len + addr mod SEG_BYTES) / SEG_BYTES) segment words.
- R5: Stream byte i lands in byte lane (addr + i) mod SEG_BYTES, with lane j in data bits [8j+7:8j] and enable bit j. On the first word, the enables below lane addr mod SEG_BYTES are 0.
- R6: On the last word, the enables at and above lane ((addr + len - 1) mod SEG_BYTES) + 1 are 0. All other enables of a word are 1.
- R7: A segment command that is valid and not ready keeps its valid, address, data and enables unchanged. A slot is reloaded only when it is empty or its command is being accepted.
- R8: Exactly one `cmpl_pulse` follows each valid request. It comes only after one done pulse has been received for every word the request issued.
- R9: `busy` is high from the cycle after a valid request is accepted until the cycle after its completion pulse, unless another request is still pending.
- R10: While one request awaits done pulses, a second can be accepted and fully issued. With one request awaiting completion and a second queued, `wreq_ready` is low.
- R11: `byte_ready` is high only while a valid request still has bytes to receive and no packed word is waiting for its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wreq_valid | input | 1 | Request offered |
| wreq_ready | output | 1 | Request taken this cycle when valid |
| wreq_addr | input | ADDR_W | Start byte address |
| wreq_len | input | ADDR_W+1 | Length in bytes |
| wreq_reject | output | 1 | Pulse: last accepted request refused |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Data byte taken this cycle when valid |
| byte_data | input | 8 | Data byte |
| sw_valid | output | SEG_COUNT | Per-segment command valid |
| sw_ready | input | SEG_COUNT | Per-segment command accept |
| sw_addr | output | SEG_COUNT*SEG_AW | Per-segment word addresses, segment s in slice s |
| sw_data | output | SEG_COUNT*SEG_BYTES*8 | Per-segment write data |
| sw_be | output | SEG_COUNT*SEG_BYTES | Per-segment byte enables |
| sw_done | input | SEG_COUNT | Per-segment write-done pulses |
| cmpl_pulse | output | 1 | Pulse: a request fully written |
| busy | output | 1 | A valid request is awaiting completion |

## Verification
The bench builds the block with two segments of four bytes and a 4-bit segment word address, which gives a 128-byte space. With this setting, requests cross segment and bus-word boundaries in just a few bytes. Both ends of the address space and both trimming edges fall within short directed cases. A bench memory model can hold back done pulses or stall its ready lines pseudo-randomly. This brings the slot hold rule and the overlap of an issuing request with one that is awaiting completion within reach.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_FILL = 2'd1,
        PK_HAND = 2'd2
    } pack_state_e;

    // Number of segment words touched by a request
    function automatic int seg_words(input int addr, input int len, input int sb);
        return (len + (addr % sb) + sb - 1) / sb;
    endfunction

    // Index of the segment holding a byte address
    function automatic int seg_of(input int addr, input int sb, input int sc);
        return (addr / sb) % sc;
    endfunction

endpackage

// File: rtl/wsplit_slot.sv
module wsplit_slot #(
    parameter int SB     = 4,
    parameter int SEG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SEG_AW-1:0] ld_addr,
    input  logic [SB*8-1:0]   ld_data,
    input  logic [SB-1:0]     ld_be,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [SEG_AW-1:0] cmd_addr,
    output logic [SB*8-1:0]   cmd_data,
    output logic [SB-1:0]     cmd_be
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            cmd_be    <= '0;
        end else if (load) begin
            cmd_valid <= 1'b1;
            cmd_addr  <= ld_addr;
            cmd_data  <= ld_data;
            cmd_be    <= ld_be;
        end else if (cmd_valid && cmd_ready) begin
            cmd_valid <= 1'b0;
        end
    end

    // R7: a stalled command holds still
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data) && $stable(cmd_be)));

    // R7: reload only into a free slot
    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
        load |-> (!cmd_valid || cmd_ready));

    // R5: a valid command always enables at least one byte
    p_be_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_be != '0));

endmodule

// File: rtl/wsplit_packer.sv
module wsplit_packer
    import wsplit_pkg::*;
#(
    parameter int SB     = 4,
    parameter int SC     = 2,
    parameter int SEG_AW = 4,
    localparam int BUS_B  = SB * SC,
    localparam int ADDR_W = SEG_AW + $clog2(BUS_B),
    localparam int LEN_W  = ADDR_W + 1,
    localparam int LANE_W = $clog2(SB),
    localparam int SEGI_W = (SC > 1) ? $clog2(SC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              trk_can_take,
    output logic              req_ready,
    output logic              rej,
    output logic              job_push,
    output logic [SEGI_W-1:0] job_seg,
    output logic [LEN_W-1:0]  job_words,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [SEGI_W-1:0] out_seg,
    output logic [SEG_AW-1:0] out_addr,
    output logic [SB*8-1:0]   out_data,
    output logic [SB-1:0]     out_be,
    input  logic              out_take
);

    localparam logic [ADDR_W+1:0] SPACE = (ADDR_W+2)'(1) << ADDR_W;

    pack_state_e       st;
    logic [LANE_W-1:0] lane;
    logic [LEN_W-1:0]  left;
    logic [ADDR_W+1:0] end_sum;
    logic              bad;
    logic              acc;

    always_comb begin
        end_sum   = {2'b00, req_addr} + {1'b0, req_len};
        bad       = (req_len == '0) || (end_sum > SPACE);
        req_ready = (st == PK_IDLE) && trk_can_take;
        acc       = req_valid && req_ready;
        job_push  = acc && !bad;
        job_seg   = SEGI_W'(seg_of(int'(req_addr), SB, SC));
        job_words = LEN_W'(seg_words(int'(req_addr), int'(req_len), SB));
        in_ready  = (st == PK_FILL);
        out_valid = (st == PK_HAND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PK_IDLE;
            rej      <= 1'b0;
            lane     <= '0;
            left     <= '0;
            out_seg  <= '0;
            out_addr <= '0;
            out_data <= '0;
            out_be   <= '0;
        end else begin
            rej <= 1'b0;
            case (st)
                PK_IDLE: begin
                    if (acc) begin
                        if (bad) begin
                            rej <= 1'b1;
                        end else begin
                            st       <= PK_FILL;
                            lane     <= req_addr[LANE_W-1:0];
                            left     <= req_len;
                            out_seg  <= job_seg;
                            out_addr <= SEG_AW'(int'(req_addr) / BUS_B);
                            out_data <= '0;
                            out_be   <= '0;
                        end
                    end
                end
                PK_FILL: begin
                    if (in_valid) begin
                        out_data[lane*8 +: 8] <= in_data;
                        out_be[lane]          <= 1'b1;
                        left                  <= left - 1'b1;
                        if ((lane == LANE_W'(SB - 1)) || (left == LEN_W'(1)))
                            st <= PK_HAND;
                        else
                            lane <= lane + 1'b1;
                    end
                end
                PK_HAND: begin
                    if (out_take) begin
                        out_data <= '0;
                        out_be   <= '0;
                        lane     <= '0;
                        if (out_seg == SEGI_W'(SC - 1)) begin
                            out_seg  <= '0;
                            out_addr <= out_addr + 1'b1;
                        end else begin
                            out_seg <= out_seg + 1'b1;
                        end
                        st <= (left == '0) ? PK_IDLE : PK_FILL;
                    end
                end
                default: st <= PK_IDLE;
            endcase
        end
    end

    // R2: a reject pulse follows an accepted request
    p_rej_after_acc_r2: assert property (@(posedge clk) disable iff (rst)
        rej |-> $past(req_valid && req_ready));

    // R7: the slot side takes a word only when one is offered
    p_take_offered_r7: assert property (@(posedge clk) disable iff (rst)
        out_take |-> out_valid);

    // R10: a new job is only pushed when the tracker has room
    p_push_room_r10: assert property (@(posedge clk) disable iff (rst)
        job_push |-> trk_can_take);

endmodule

// File: rtl/wsplit_tracker.sv
module wsplit_tracker #(
    parameter int SC     = 2,
    parameter int LEN_W  = 8,
    localparam int SEGI_W = (SC > 1) ? $clog2(SC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SC-1:0]     done,
    input  logic              job_push,
    input  logic [SEGI_W-1:0] job_seg,
    input  logic [LEN_W-1:0]  job_words,
    output logic              can_take,
    output logic              busy,
    output logic              cpl
);

    logic [LEN_W-1:0]  cnt [SC];
    logic              act_v, q_v;
    logic [SEGI_W-1:0] act_seg, q_seg;
    logic [LEN_W-1:0]  act_left, q_words;
    logic              consume, pop;

    always_comb begin
        consume  = act_v && (cnt[act_seg] != '0);
        pop      = consume && (act_left == LEN_W'(1));
        can_take = !q_v;
        busy     = act_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SC; s++) cnt[s] <= '0;
            act_v    <= 1'b0;
            q_v      <= 1'b0;
            act_seg  <= '0;
            q_seg    <= '0;
            act_left <= '0;
            q_words  <= '0;
            cpl      <= 1'b0;
        end else begin
            cpl <= 1'b0;
            for (int s = 0; s < SC; s++) begin
                cnt[s] <= cnt[s] + LEN_W'(done[s])
                          - LEN_W'(consume && (act_seg == SEGI_W'(s)));
            end
            if (consume) begin
                act_seg  <= (act_seg == SEGI_W'(SC - 1)) ? '0 : act_seg + 1'b1;
                act_left <= act_left - 1'b1;
            end
            if (pop) begin
                cpl <= 1'b1;
                if (q_v) begin
                    act_seg  <= q_seg;
                    act_left <= q_words;
                    q_v      <= 1'b0;
                end else begin
                    act_v <= 1'b0;
                end
            end
            if (job_push) begin
                if ((!act_v || pop) && !q_v) begin
                    act_v    <= 1'b1;
                    act_seg  <= job_seg;
                    act_left <= job_words;
                end else begin
                    q_v     <= 1'b1;
                    q_seg   <= job_seg;
                    q_words <= job_words;
                end
            end
        end
    end

    // R8: completion only while a request was outstanding
    p_cpl_busy_r8: assert property (@(posedge clk) disable iff (rst)
        cpl |-> $past(act_v));

    // R10: no push arrives while both positions are held
    p_no_push_full_r10: assert property (@(posedge clk) disable iff (rst)
        job_push |-> !q_v);

    for (genvar g = 0; g < SC; g++) begin : g_ovf
        // R8: per-segment done counter never wraps
        p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
            done[g] |-> (cnt[g] != '1));
    end

endmodule

// File: rtl/wsplit_write_splitter.sv
module wsplit_write_splitter #(
    parameter int SEG_COUNT = 2,
    parameter int SEG_BYTES = 4,
    parameter int SEG_AW    = 4,
    localparam int BUS_B  = SEG_BYTES * SEG_COUNT,
    localparam int ADDR_W = SEG_AW + $clog2(BUS_B),
    localparam int LEN_W  = ADDR_W + 1,
    localparam int SEG_DW = SEG_BYTES * 8,
    localparam int SEGI_W = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wreq_valid,
    output logic                          wreq_ready,
    input  logic [ADDR_W-1:0]             wreq_addr,
    input  logic [LEN_W-1:0]              wreq_len,
    output logic                          wreq_reject,
    input  logic                          byte_valid,
    output logic                          byte_ready,
    input  logic [7:0]                    byte_data,
    output logic [SEG_COUNT-1:0]          sw_valid,
    input  logic [SEG_COUNT-1:0]          sw_ready,
    output logic [SEG_COUNT*SEG_AW-1:0]   sw_addr,
    output logic [SEG_COUNT*SEG_DW-1:0]   sw_data,
    output logic [SEG_COUNT*SEG_BYTES-1:0] sw_be,
    input  logic [SEG_COUNT-1:0]          sw_done,
    output logic                          cmpl_pulse,
    output logic                          busy
);

    logic              trk_can_take;
    logic              job_push;
    logic [SEGI_W-1:0] job_seg;
    logic [LEN_W-1:0]  job_words;
    logic              pk_valid;
    logic [SEGI_W-1:0] pk_seg;
    logic [SEG_AW-1:0] pk_addr;
    logic [SEG_DW-1:0] pk_data;
    logic [SEG_BYTES-1:0] pk_be;
    logic              pk_take;
    logic [SEG_COUNT-1:0] slot_free;
    logic [SEG_COUNT-1:0] slot_load;

    wsplit_packer #(.SB(SEG_BYTES), .SC(SEG_COUNT), .SEG_AW(SEG_AW)) u_pack (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (wreq_valid),
        .req_addr    (wreq_addr),
        .req_len     (wreq_len),
        .trk_can_take(trk_can_take),
        .req_ready   (wreq_ready),
        .rej         (wreq_reject),
        .job_push    (job_push),
        .job_seg     (job_seg),
        .job_words   (job_words),
        .in_valid    (byte_valid),
        .in_data     (byte_data),
        .in_ready    (byte_ready),
        .out_valid   (pk_valid),
        .out_seg     (pk_seg),
        .out_addr    (pk_addr),
        .out_data    (pk_data),
        .out_be      (pk_be),
        .out_take    (pk_take)
    );

    always_comb begin
        slot_free = ~sw_valid | sw_ready;
        pk_take   = pk_valid && slot_free[pk_seg];
        for (int s = 0; s < SEG_COUNT; s++)
            slot_load[s] = pk_take && (pk_seg == SEGI_W'(s));
    end

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_slot
        wsplit_slot #(.SB(SEG_BYTES), .SEG_AW(SEG_AW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (slot_load[g]),
            .ld_addr  (pk_addr),
            .ld_data  (pk_data),
            .ld_be    (pk_be),
            .cmd_ready(sw_ready[g]),
            .cmd_valid(sw_valid[g]),
            .cmd_addr (sw_addr[g*SEG_AW +: SEG_AW]),
            .cmd_data (sw_data[g*SEG_DW +: SEG_DW]),
            .cmd_be   (sw_be[g*SEG_BYTES +: SEG_BYTES])
        );
    end

    wsplit_tracker #(.SC(SEG_COUNT), .LEN_W(LEN_W)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .done     (sw_done),
        .job_push (job_push),
        .job_seg  (job_seg),
        .job_words(job_words),
        .can_take (trk_can_take),
        .busy     (busy),
        .cpl      (cmpl_pulse)
    );

    // R11: bytes are only taken while no request is waiting to be accepted
    p_byte_vs_req_r11: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> !wreq_ready);

    // R9: completion implies the busy flag was up
    p_cpl_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |-> $past(busy));

endmodule

// File: tb/wsplit_write_splitter_test.sv
module wsplit_write_splitter_test;

    localparam int CLK_NS = 10;
    localparam int SC     = 2;
    localparam int SB     = 4;
    localparam int SAW    = 4;
    localparam int BUS_B  = SB * SC;
    localparam int ADDR_W = SAW + $clog2(BUS_B);
    localparam int LEN_W  = ADDR_W + 1;
    localparam int SPACE  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wreq_valid = 1'b0;
    logic wreq_ready;
    logic [ADDR_W-1:0] wreq_addr = '0;
    logic [LEN_W-1:0]  wreq_len = '0;
    logic wreq_reject;
    logic byte_valid = 1'b0;
    logic byte_ready;
    logic [7:0] byte_data = '0;
    logic [SC-1:0] sw_valid;
    logic [SC-1:0] sw_ready;
    logic [SC*SAW-1:0] sw_addr;
    logic [SC*SB*8-1:0] sw_data;
    logic [SC*SB-1:0] sw_be;
    logic [SC-1:0] sw_done;
    logic cmpl_pulse;
    logic busy;

    always #(CLK_NS/2) clk = ~clk;

    wsplit_write_splitter #(.SEG_COUNT(SC), .SEG_BYTES(SB), .SEG_AW(SAW)) uut (
        .clk(clk), .rst(rst),
        .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_addr(wreq_addr),
        .wreq_len(wreq_len), .wreq_reject(wreq_reject),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_addr(sw_addr), .sw_data(sw_data),
        .sw_be(sw_be), .sw_done(sw_done), .cmpl_pulse(cmpl_pulse), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] mem [SPACE];
    logic [7:0] exp_mem [SPACE];
    int pend [SC];
    int log_seg [64];
    int log_addr [64];
    int log_be [64];
    int log_n = 0;
    int cpl_n = 0;
    int rej_n = 0;
    bit stall_mode = 0;
    bit hold_done = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Segmented RAM model with done pulses and optional stalls
    always @(posedge clk) begin
        if (rst) begin
            sw_ready <= '0;
            sw_done  <= '0;
            for (int s = 0; s < SC; s++) pend[s] = 0;
        end else begin
            if (cmpl_pulse) cpl_n = cpl_n + 1;
            if (wreq_reject) rej_n = rej_n + 1;
            for (int s = 0; s < SC; s++) begin
                if (sw_valid[s] && sw_ready[s]) begin
                    int wa;
                    wa = int'(sw_addr[s*SAW +: SAW]);
                    if (log_n < 64) begin
                        log_seg[log_n]  = s;
                        log_addr[log_n] = wa;
                        log_be[log_n]   = int'(sw_be[s*SB +: SB]);
                    end
                    log_n = log_n + 1;
                    for (int j = 0; j < SB; j++)
                        if (sw_be[s*SB + j])
                            mem[(wa*SC + s)*SB + j] = sw_data[(s*SB + j)*8 +: 8];
                    pend[s] = pend[s] + 1;
                end
                if (!hold_done && pend[s] > 0) begin
                    sw_done[s] <= 1'b1;
                    pend[s] = pend[s] - 1;
                end else begin
                    sw_done[s] <= 1'b0;
                end
                sw_ready[s] <= stall_mode ? lfsr[s*3] : 1'b1;
            end
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send_req(input int addr, input int len);
        @(negedge clk);
        wreq_valid = 1'b1;
        wreq_addr  = ADDR_W'(addr);
        wreq_len   = LEN_W'(len);
        while (!wreq_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        wreq_valid = 1'b0;
    endtask

    task automatic send_bytes(input int addr, input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(seed + i * 7);
            exp_mem[addr + i] = b;
            byte_valid = 1'b1;
            byte_data  = b;
            while (!byte_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic wait_cpl(input int target, input string tag);
        int n = 0;
        while (cpl_n < target && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(cpl_n == target, tag, cpl_n, target);
    endtask

    task automatic check_mem(input string tag);
        int mism = 0;
        int first = -1;
        for (int a = 0; a < SPACE; a++)
            if (mem[a] !== exp_mem[a]) begin
                mism++;
                if (first < 0) first = a;
            end
        check(mism == 0, tag, first, -1);
    endtask

    // Compare issued command log against the addressing rules
    task automatic verify_log(input int addr, input int len);
        int words = (len + addr % SB + SB - 1) / SB;
        int so = addr % SB;
        int eo = ((addr + len - 1) % SB) + 1;
        check(log_n == words, "R4 word count", log_n, words);
        for (int k = 0; k < words && k < log_n && k < 64; k++) begin
            int es = ((addr / SB) + k) % SC;
            int ea = (addr + k * SB) / BUS_B;
            int eb = (1 << SB) - 1;
            if (k == 0) eb = eb & (((1 << SB) - 1) << so);
            if (k == words - 1) eb = eb & ((1 << eo) - 1);
            check(log_seg[k] == es, "R3 segment index", log_seg[k], es);
            check(log_addr[k] == ea, "R3 word address", log_addr[k], ea);
            if (k == words - 1)
                check(log_be[k] == eb, "R6 last enables", log_be[k], eb);
            else
                check(log_be[k] == eb, "R5 enables", log_be[k], eb);
        end
    endtask

    task automatic do_write(input int addr, input int len, input int seed, input string tag);
        int c0 = cpl_n;
        log_n = 0;
        send_req(addr, len);
        check(busy == 1'b1, "R9 busy after accept", busy, 1);
        send_bytes(addr, len, seed);
        wait_cpl(c0 + 1, "R8 completion count");
        @(negedge clk);
        check(busy == 1'b0, "R9 busy after completion", busy, 0);
        if (!stall_mode) verify_log(addr, len);
        check_mem({"R5 R6 memory ", tag});
    endtask

    task automatic t_reset;
        check(sw_valid == '0, "R1 command valid", int'(sw_valid), 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(wreq_ready == 1'b1, "R1 request ready", wreq_ready, 1);
        check(byte_ready == 1'b0, "R1 byte ready", byte_ready, 0);
        check(cmpl_pulse == 1'b0 && wreq_reject == 1'b0, "R1 pulses", int'(cmpl_pulse), 0);
    endtask

    task automatic t_reject(input int addr, input int len);
        int r0 = rej_n;
        int c0 = cpl_n;
        log_n = 0;
        send_req(addr, len);
        check(byte_ready == 1'b0, "R2 byte ready after reject", byte_ready, 0);
        @(negedge clk);
        check(rej_n == r0 + 1, "R2 reject pulse", rej_n, r0 + 1);
        repeat (4) @(negedge clk);
        check(log_n == 0, "R2 nothing issued", log_n, 0);
        check(busy == 1'b0, "R2 busy low", busy, 0);
        check(cpl_n == c0, "R2 no completion", cpl_n, c0);
        check_mem("R2 memory untouched");
    endtask

    task automatic t_overlap;
        int c0 = cpl_n;
        hold_done = 1;
        send_req(16, 4);
        send_bytes(16, 4, 8'h31);
        send_req(42, 6);
        send_bytes(42, 6, 8'h52);
        repeat (6) @(negedge clk);
        check(cpl_n == c0, "R8 no completion while done held", cpl_n, c0);
        check(busy == 1'b1, "R9 busy while awaiting done", busy, 1);
        wreq_valid = 1'b1;
        wreq_addr  = ADDR_W'(100);
        wreq_len   = LEN_W'(2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(wreq_ready == 1'b0, "R10 ready low when full", wreq_ready, 0);
        end
        wreq_valid = 1'b0;
        hold_done = 0;
        wait_cpl(c0 + 2, "R10 both completions");
        @(negedge clk);
        check(busy == 1'b0, "R9 busy low after both", busy, 0);
        check_mem("R10 memory after overlap");
    endtask

    initial begin
        for (int a = 0; a < SPACE; a++) begin
            mem[a] = 8'h00;
            exp_mem[a] = 8'h00;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();

        do_write(5, 2, 8'h10, "inside one word");
        do_write(6, 9, 8'h20, "three words");
        do_write(0, 8, 8'h40, "aligned bus word");
        do_write(27, 14, 8'h60, "odd crossing");
        do_write(127, 1, 8'h77, "top byte");
        do_write(124, 4, 8'h88, "ends at space limit");
        t_reject(125, 4);
        t_reject(20, 0);
        t_reject(0, 200);
        t_overlap();

        stall_mode = 1;
        do_write(3, 29, 8'h90, "R7 stalled long");
        do_write(64, 40, 8'hA3, "R7 stalled aligned");
        stall_mode = 0;
        repeat (4) @(negedge clk);
        check(sw_valid == '0, "R11 idle after stalls", int'(sw_valid), 0);
        check(byte_ready == 1'b0, "R11 byte ready idle", byte_ready, 0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule